// File: doc/BRIEF.md
# Battery-Backup Mode Controller

This block decides whether a supervised system runs from its main supply or from its backup battery. It receives three digital comparator flags from the analog front end: the supply is above the reset threshold, the supply is above the battery (hysteresis is already applied by the comparator), and the supply is far below the battery. Each flag is filtered so that it only counts once it has held a new value for `DEB_LEN` consecutive clock samples. The filtered flags drive a three-state mode machine with the states main, battery and hold.

The machine enters battery mode only when the filtered flags show the supply below the reset threshold and below the battery at the same time. While in battery mode it raises the battery-on flag and the source select. It also drives override enables that the surrounding supervisor uses:
- the watchdog fault output is held high;
- the gated chip-enable is held high, with its input disconnected;
- reset and the low-line flag are held low.

In deep backup it also forces the power-fail output low.

When either entry condition clears, the source returns to the main supply. The overrides stay on in a hold state until the reset sequencer reports the supply good again, so the sequencer controls their release.

Top module: `bkp_mode_ctrl`

## Requirements
- R1: While reset is applied, and after it is released with the flags idle (above threshold = 1, above battery = 1, far below = 0), every output is 0.
- R2: A flag counts only after it has differed from its filtered value on `DEB_LEN` consecutive rising clock edges. A shorter excursion changes no output.
- R3: The supply below the threshold alone, or the supply below the battery alone, never selects battery mode.
- R4: When both filtered conditions hold in main or hold mode, `bat_on` and `src_is_bat` go to 1 (1 = battery) `DEB_LEN`+1 edges after the raw flags change. Outside battery mode both are 0.
- R5: In battery mode, `wdo_hold_hi`, `ce_hold_hi` and `rst_hold_lo` are all 1.
- R6: `pfo_hold_lo` is 1 only in battery mode while the filtered far-below flag is 1. In main mode the far-below flag has no effect.
- R7: In battery mode, a filtered flag showing the supply above the threshold or above the battery moves the block to hold mode. In hold mode `bat_on`, `src_is_bat` and `pfo_hold_lo` are 0, and `wdo_hold_hi`, `ce_hold_hi` and `rst_hold_lo` stay 1.
- R8: In hold mode, `supply_ok_seen` = 1 (unless both entry conditions hold) returns the block to main mode on the next edge, clearing all overrides. In main and battery mode this input has no effect.
- R9: From hold mode, both entry conditions holding again return the block to battery mode, with priority over `supply_ok_seen`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vcc_above_thr | input | 1 | Supply above reset threshold |
| vcc_above_bat | input | 1 | Supply above battery (with hysteresis) |
| vcc_far_below_bat | input | 1 | Supply far below battery |
| supply_ok_seen | input | 1 | Reset sequencer reports supply good again |
| bat_on | output | 1 | Battery-on indicator |
| src_is_bat | output | 1 | Power-source select, 1 = battery |
| wdo_hold_hi | output | 1 | Force watchdog fault output high |
| ce_hold_hi | output | 1 | Force gated chip-enable high, input disconnected |
| rst_hold_lo | output | 1 | Force reset and low-line low |
| pfo_hold_lo | output | 1 | Force power-fail output low |

## Verification
A change on a comparator flag reaches the filtered register on the `DEB_LEN`-th edge at which it differs. The mode register and all outputs follow one edge later, so the outputs respond `DEB_LEN`+1 edges after the flag change. `supply_ok_seen` is not filtered and takes effect one edge after it is sampled. `pfo_hold_lo` follows the far-below flag `DEB_LEN` edges after that flag changes, as long as the block is already in battery mode. The bench drives inputs shortly after each rising edge. A behavioural model steps on the same edges, and all six outputs are compared with it at every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bkp_pkg.sv
package bkp_pkg;
  typedef enum logic [1:0] {
    MODE_MAIN = 2'd0,
    MODE_BAT  = 2'd1,
    MODE_HOLD = 2'd2
  } mode_t;

  localparam int FLAG_CNT  = 3;
  localparam int IDX_THR   = 0;
  localparam int IDX_BAT   = 1;
  localparam int IDX_DEEP  = 2;
  localparam logic [FLAG_CNT-1:0] FLAG_IDLE = 3'b011;
endpackage

// File: rtl/bkp_rst_sync.sv
module bkp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/bkp_flag_filter.sv
module bkp_flag_filter #(
  parameter int   DEB_LEN = 4,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DEB_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;

  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (raw != filt_q) begin
      if (cnt_q == CNT_LAST) filt_d = raw;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;

  // R2: the filtered value moves only toward a raw value already sampled
  a_r2_filter_follows_raw: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> $past(raw) == filt_q);
endmodule

// File: rtl/bkp_mode_fsm.sv
module bkp_mode_fsm
  import bkp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic thr_ok,
  input  logic above_bat,
  input  logic deep_low,
  input  logic sup_ok_seen,
  output logic bat_on,
  output logic src_is_bat,
  output logic wdo_hold_hi,
  output logic ce_hold_hi,
  output logic rst_hold_lo,
  output logic pfo_hold_lo
);
  mode_t mode_q, mode_d;
  logic  enter_bat;

  assign enter_bat = !thr_ok && !above_bat;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MODE_MAIN: if (enter_bat) mode_d = MODE_BAT;
      MODE_BAT:  if (!enter_bat) mode_d = MODE_HOLD;
      MODE_HOLD: begin
        if (enter_bat)        mode_d = MODE_BAT;
        else if (sup_ok_seen) mode_d = MODE_MAIN;
      end
      default:   mode_d = MODE_MAIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_MAIN;
    else        mode_q <= mode_d;
  end

  assign bat_on      = (mode_q == MODE_BAT);
  assign src_is_bat  = (mode_q == MODE_BAT);
  assign wdo_hold_hi = (mode_q != MODE_MAIN);
  assign ce_hold_hi  = (mode_q != MODE_MAIN);
  assign rst_hold_lo = (mode_q != MODE_MAIN);
  assign pfo_hold_lo = (mode_q == MODE_BAT) && deep_low;

  // R3: battery mode starts only after both entry conditions were seen
  a_r3_entry_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bat_on) |-> $past(!thr_ok && !above_bat));
  // R5: battery mode always carries the output overrides
  a_r5_overrides_in_bat: assert property (@(posedge clk) disable iff (!rst_n)
    bat_on |-> (wdo_hold_hi && ce_hold_hi && rst_hold_lo));
  // R6: power-fail forcing only inside battery mode
  a_r6_pfo_only_in_bat: assert property (@(posedge clk) disable iff (!rst_n)
    pfo_hold_lo |-> bat_on);
  // R8: overrides drop only after the sequencer reported supply good
  a_r8_release_on_report: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_hold_lo) |-> $past(sup_ok_seen));
endmodule

// File: rtl/bkp_mode_ctrl.sv
module bkp_mode_ctrl
  import bkp_pkg::*;
#(
  parameter int DEB_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vcc_above_thr,
  input  logic vcc_above_bat,
  input  logic vcc_far_below_bat,
  input  logic supply_ok_seen,
  output logic bat_on,
  output logic src_is_bat,
  output logic wdo_hold_hi,
  output logic ce_hold_hi,
  output logic rst_hold_lo,
  output logic pfo_hold_lo
);
  logic                rst_int_n;
  logic [FLAG_CNT-1:0] raw_flags;
  logic [FLAG_CNT-1:0] filt_flags;

  assign raw_flags[IDX_THR]  = vcc_above_thr;
  assign raw_flags[IDX_BAT]  = vcc_above_bat;
  assign raw_flags[IDX_DEEP] = vcc_far_below_bat;

  bkp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flt
    bkp_flag_filter #(
      .DEB_LEN (DEB_LEN),
      .RST_VAL (FLAG_IDLE[i])
    ) u_flt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .raw   (raw_flags[i]),
      .filt  (filt_flags[i])
    );
  end

  bkp_mode_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .thr_ok      (filt_flags[IDX_THR]),
    .above_bat   (filt_flags[IDX_BAT]),
    .deep_low    (filt_flags[IDX_DEEP]),
    .sup_ok_seen (supply_ok_seen),
    .bat_on      (bat_on),
    .src_is_bat  (src_is_bat),
    .wdo_hold_hi (wdo_hold_hi),
    .ce_hold_hi  (ce_hold_hi),
    .rst_hold_lo (rst_hold_lo),
    .pfo_hold_lo (pfo_hold_lo)
  );

  // R1: out of reset the block is in main mode with no override
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |=> !bat_on || rst_int_n);
  // R7: leaving battery mode never drops the reset override in the same step
  a_r7_hold_keeps_reset: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(bat_on) |-> rst_hold_lo);
endmodule

// File: tb/test_bkp_mode_ctrl.sv
module test_bkp_mode_ctrl;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr = 1'b1, abv = 1'b1, deep = 1'b0, sok = 1'b0;
  logic bat_on, src_is_bat, wdo_h, ce_h, rst_h, pfo_h;

  bkp_mode_ctrl #(.DEB_LEN(DEB)) i_bkp_mode_ctrl (
    .clk               (clk),
    .rst_n             (rst_n),
    .vcc_above_thr     (thr),
    .vcc_above_bat     (abv),
    .vcc_far_below_bat (deep),
    .supply_ok_seen    (sok),
    .bat_on            (bat_on),
    .src_is_bat        (src_is_bat),
    .wdo_hold_hi       (wdo_h),
    .ce_hold_hi        (ce_h),
    .rst_hold_lo       (rst_h),
    .pfo_hold_lo       (pfo_h)
  );

  always #10 clk = ~clk;

  int    vectors = 0, errors = 0, cycles = 0;
  bit    done = 0;
  string phase = "R1 reset";

  // behavioural reference: 0 main, 1 battery, 2 hold
  int m_mode = 0;
  int m_run[3];
  bit m_flt[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_flt[0] = 1; m_flt[1] = 1; m_flt[2] = 0;
      foreach (m_run[k]) m_run[k] = 0;
    end else begin
      bit both;
      bit raw[3];
      both = !m_flt[0] && !m_flt[1];
      case (m_mode)
        0: if (both) m_mode = 1;
        1: if (!both) m_mode = 2;
        default: if (both) m_mode = 1; else if (sok) m_mode = 0;
      endcase
      raw[0] = thr; raw[1] = abv; raw[2] = deep;
      for (int k = 0; k < 3; k++) begin
        if (raw[k] != m_flt[k]) begin
          m_run[k]++;
          if (m_run[k] >= DEB) begin m_flt[k] = raw[k]; m_run[k] = 0; end
        end else m_run[k] = 0;
      end
    end
  end

  task automatic cmp(string nm, logic act, bit exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at cycle %0d", phase, nm, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      cmp("bat_on",      bat_on,     m_mode == 1);
      cmp("src_is_bat",  src_is_bat, m_mode == 1);
      cmp("wdo_hold_hi", wdo_h,      m_mode != 0);
      cmp("ce_hold_hi",  ce_h,       m_mode != 0);
      cmp("rst_hold_lo", rst_h,      m_mode != 0);
      cmp("pfo_hold_lo", pfo_h,      m_mode == 1 && m_flt[2]);
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog: got hang expected finish");
        finish_run();
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;                       // R1: idle after release
    wait_cyc(6);

    phase = "R2 short glitch";          // R2: DEB-1 samples, no effect
    thr = 0; abv = 0; wait_cyc(DEB - 1);
    thr = 1; abv = 1; wait_cyc(8);

    phase = "R3 threshold only";        // R3
    thr = 0; wait_cyc(10);
    phase = "R3 battery only";
    thr = 1; abv = 0; wait_cyc(10);

    phase = "R6 deep in main";          // R6: no effect in main mode
    deep = 1; wait_cyc(8);
    deep = 0; wait_cyc(8);

    phase = "R4 R5 entry";              // R4 R5
    thr = 0; wait_cyc(10);

    phase = "R6 deep in battery";       // R6
    deep = 1; wait_cyc(8);
    deep = 0; wait_cyc(8);

    phase = "R8 report ignored in battery";
    sok = 1; wait_cyc(3); sok = 0; wait_cyc(3);

    phase = "R7 exit to hold";          // R7
    abv = 1; wait_cyc(10);

    phase = "R9 re-entry from hold";    // R9 with report asserted
    abv = 0; sok = 0; wait_cyc(DEB);
    sok = 1; wait_cyc(6); sok = 0; wait_cyc(4);

    phase = "R7 exit via threshold";
    thr = 1; wait_cyc(10);

    phase = "R8 release on report";     // R8
    sok = 1; wait_cyc(1); sok = 0; wait_cyc(6);

    phase = "R8 report ignored in main";
    abv = 1; sok = 1; wait_cyc(6); sok = 0; wait_cyc(4);

    phase = "R1 reset mid battery";
    thr = 0; abv = 0; wait_cyc(10);
    rst_n = 0; thr = 1; abv = 1; wait_cyc(3);
    rst_n = 1; wait_cyc(8);

    finish_run();
  end
endmodule